// File: doc/BRIEF.md
# Register-Stack Floating-Point Arithmetic Dispatcher

This block is the control and operand-steering stage of a floating-point unit that keeps its operands in an eight-entry register stack. It accepts one decoded two-operand command at a time. The command names a 3-bit operation and a second operand, which is either a value already converted to internal format or a stack register STi. It also carries a flag that sends the result to the stack top or to STi, a pop request and the invalid-operation mask. The block owns the stack pointer, the per-register tags and the register contents. It checks the tags for empty operands before any work starts. It hands one ordered operand pair to an external arithmetic port and then writes back the returned result or compare flags.

The first operand is always the stack top. Reverse operations swap the pair, so the direction comes from the opcode and never from which register receives the result. An invalid-operation fault caused by an empty operand is handled in one of two ways. If it is masked, the destination receives the indefinite NaN. If it is unmasked, the stack is left untouched and an exception is flagged. A load port pushes values onto the stack, and a combinational read port returns any STi with its tag.

The controller steps through four named states. IDLE accepts a command (transition *accept*, IDLE→EVAL). EVAL checks the tags. On a fault it writes the masked response or flags the exception (transition *fault*, EVAL→IDLE); otherwise it moves on (transition *go*, EVAL→ISSUE). ISSUE holds the request until the port takes it (transition *taken*, ISSUE→WAIT). WAIT writes back and pops when the response arrives (transition *retire*, WAIT→IDLE).

Top module: `fpd_dispatch`

## Requirements
- R1: After reset the stack pointer is 0, all eight tags read empty, compare flags are 0, the sticky invalid flag and exception-pending are low, and the block is ready for a command.
- R2: A load (accepted only while ready) decrements the stack pointer modulo 8 and writes the value and tag into the new ST0. The tag encoding is 0 valid, 1 zero, 2 special, 3 empty, and STi is physical register (pointer + i) mod 8.
- R3: Operation codes are 0 add, 1 multiply, 2 compare, 3 compare-and-pop, 4 subtract, 5 reverse subtract, 6 divide, 7 reverse divide. Codes 0, 1, 2, 3, 4 and 6 send A = ST0 and B = other. Codes 5 and 7 send A = other and B = ST0. The port operation is the code with 5→4, 7→6 and 3→2.
- R4: A result is written to ST0 when the top-destination flag is set or the operand comes from memory, and to STi otherwise. Its tag is the 2-bit class returned with the result.
- R5: Codes 2 and 3 load the compare flags from the port's 4-bit flags and write no data register. Code 3 pops once.
- R6: For the register form a pop request pops once after the result is written: the old top is tagged empty and the pointer increments modulo 8. A pop request with a memory operand has no effect.
- R7: If ST0 is empty, or STi is empty on the register form, no arithmetic request is issued and the sticky invalid flag is set.
- R8: On such a fault with the mask set, the destination register receives the indefinite NaN (sign 1, exponent all ones, mantissa top two bits 1 and the rest 0), it is tagged special, and no pop occurs.
- R9: On such a fault with the mask clear, no register, tag or pointer changes, and exception-pending stays high until the next command is accepted.
- R10: At most one request is outstanding. The request valid holds with stable operands and operation until ready, and the block is not ready for commands while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle; command or load accepted |
| cmd_op | input | 3 | Operation code |
| cmd_use_mem | input | 1 | Second operand comes from cmd_mem_val |
| cmd_mem_val | input | W | Converted memory operand |
| cmd_idx | input | 3 | Stack index i of STi |
| cmd_to_top | input | 1 | Result goes to ST0 (else STi) |
| cmd_pop | input | 1 | Pop after write (register form only) |
| cmd_mask | input | 1 | Invalid-operation exception masked |
| push_valid | input | 1 | Load a value onto the stack |
| push_val | input | W | Value to load |
| push_tag | input | 2 | Tag of the loaded value |
| rd_idx | input | 3 | Read-port stack index |
| rd_val | output | W | Contents of ST[rd_idx] |
| rd_tag | output | 2 | Tag of ST[rd_idx] |
| ar_valid | output | 1 | Arithmetic request valid |
| ar_ready | input | 1 | Arithmetic port accepts request |
| ar_op | output | 3 | Normalised operation for the port |
| ar_a | output | W | First operand |
| ar_b | output | W | Second operand |
| rs_valid | input | 1 | Response present |
| rs_value | input | W | Returned result |
| rs_class | input | 2 | Tag class of result |
| rs_flags | input | 4 | Returned compare flags |
| cc_flags | output | 4 | Current compare flags |
| top_ptr | output | 3 | Stack pointer |
| inv_sticky | output | 1 | Sticky invalid-operation flag |
| exc_pending | output | 1 | Unmasked invalid exception pending |

## Verification
The bench builds the block with a 5-bit exponent and a 10-bit mantissa. Each register is then a 16-bit word whose sign, exponent and mantissa fields can be read at a glance, and the indefinite NaN is the single constant 16'hFF00. The stack keeps its full eight entries, so the bench reaches pointer wrap-around through pops past register 7. It also reaches writeback to STi combined with a pop, and masked and unmasked faults on both the top-only check and the ST0-plus-STi check.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    typedef enum logic [1:0] {
        TAG_VALID   = 2'd0,
        TAG_ZERO    = 2'd1,
        TAG_SPECIAL = 2'd2,
        TAG_EMPTY   = 2'd3
    } fpd_tag_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_CMP  = 3'd2,
        OP_CMPP = 3'd3,
        OP_SUB  = 3'd4,
        OP_SUBR = 3'd5,
        OP_DIV  = 3'd6,
        OP_DIVR = 3'd7
    } fpd_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVAL  = 2'd1,
        S_ISSUE = 2'd2,
        S_WAIT  = 2'd3
    } fpd_state_e;
endpackage

// File: rtl/fpd_stack.sv
module fpd_stack
    import fpd_pkg::*;
#(
    parameter int W = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [W-1:0]     push_val,
    input  logic [1:0]       push_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_val,
    input  logic [1:0]       wr_tag,
    input  logic             pop_en,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [W-1:0]     ra_val,
    output logic [1:0]       ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [W-1:0]     rb_val,
    output logic [1:0]       rb_tag,
    input  logic [IDX_W-1:0] rc_idx,
    output logic [W-1:0]     rc_val,
    output logic [1:0]       rc_tag,
    output logic [IDX_W-1:0] top_o
);
    logic [W-1:0]     regs [DEPTH];
    logic [1:0]       tags [DEPTH];
    logic [IDX_W-1:0] top;
    logic [IDX_W-1:0] top_dn;
    logic [IDX_W-1:0] wr_phys;

    assign top_dn  = top - IDX_W'(1);
    assign wr_phys = top + wr_idx;
    assign top_o   = top;

    assign ra_val = regs[IDX_W'(top + ra_idx)];
    assign ra_tag = tags[IDX_W'(top + ra_idx)];
    assign rb_val = regs[IDX_W'(top + rb_idx)];
    assign rb_tag = tags[IDX_W'(top + rb_idx)];
    assign rc_val = regs[IDX_W'(top + rc_idx)];
    assign rc_tag = tags[IDX_W'(top + rc_idx)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                regs[k] <= '0;
                tags[k] <= TAG_EMPTY;
            end
        end else if (push_en) begin
            top          <= top_dn;
            regs[top_dn] <= push_val;
            tags[top_dn] <= push_tag;
        end else begin
            if (wr_en) begin
                regs[wr_phys] <= wr_val;
                tags[wr_phys] <= wr_tag;
            end
            // pop follows the write: the emptied tag wins on the old top
            if (pop_en) begin
                tags[top] <= TAG_EMPTY;
                top       <= top + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/fpd_route.sv
module fpd_route
    import fpd_pkg::*;
#(
    parameter int W = 80
) (
    input  logic [2:0]   op,
    input  logic         use_mem,
    input  logic [W-1:0] mem_val,
    input  logic [W-1:0] st0_val,
    input  logic [W-1:0] sti_val,
    output logic [W-1:0] a,
    output logic [W-1:0] b,
    output logic [2:0]   port_op
);
    logic         rev;
    logic [W-1:0] other;

    assign rev   = (op == OP_SUBR) || (op == OP_DIVR);
    assign other = use_mem ? mem_val : sti_val;
    assign a     = rev ? other : st0_val;
    assign b     = rev ? st0_val : other;

    always_comb begin
        unique case (op)
            OP_SUBR: port_op = OP_SUB;
            OP_DIVR: port_op = OP_DIV;
            OP_CMPP: port_op = OP_CMP;
            default: port_op = op;
        endcase
    end
endmodule

// File: rtl/fpd_ctrl.sv
module fpd_ctrl
    import fpd_pkg::*;
#(
    parameter int W = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_use_mem,
    input  logic [W-1:0]     cmd_mem_val,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             cmd_to_top,
    input  logic             cmd_pop,
    input  logic             cmd_mask,
    input  logic [1:0]       tag0,
    input  logic [1:0]       tagi,
    input  logic             ar_ready,
    input  logic             rs_valid,
    input  logic [1:0]       rs_class,
    input  logic [3:0]       rs_flags,
    output logic             cmd_ready,
    output logic             ar_valid,
    output logic [2:0]       q_op,
    output logic             q_use_mem,
    output logic [W-1:0]     q_mem_val,
    output logic [IDX_W-1:0] q_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_nan,
    output logic [1:0]       wr_class,
    output logic             pop_en,
    output logic [3:0]       cc_flags,
    output logic             inv_sticky,
    output logic             exc_pending
);
    fpd_state_e state, nxt;
    logic q_to_top, q_pop, q_mask;
    logic fault, is_cmp, do_pop;

    assign fault  = (tag0 == TAG_EMPTY) || (!q_use_mem && tagi == TAG_EMPTY);
    assign is_cmp = (q_op == OP_CMP) || (q_op == OP_CMPP);
    assign do_pop = (q_op == OP_CMPP) || (q_pop && !q_use_mem);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_op        <= '0;
            q_use_mem   <= 1'b0;
            q_mem_val   <= '0;
            q_idx       <= '0;
            q_to_top    <= 1'b0;
            q_pop       <= 1'b0;
            q_mask      <= 1'b0;
            cc_flags    <= '0;
            inv_sticky  <= 1'b0;
            exc_pending <= 1'b0;
        end else begin
            if (state == S_IDLE && cmd_valid) begin
                q_op        <= cmd_op;
                q_use_mem   <= cmd_use_mem;
                q_mem_val   <= cmd_mem_val;
                q_idx       <= cmd_idx;
                q_to_top    <= cmd_to_top;
                q_pop       <= cmd_pop;
                q_mask      <= cmd_mask;
                exc_pending <= 1'b0;
            end
            if (state == S_EVAL && fault) begin
                inv_sticky <= 1'b1;
                if (!q_mask) exc_pending <= 1'b1;
            end
            if (state == S_WAIT && rs_valid && is_cmp) cc_flags <= rs_flags;
        end
    end

    always_comb begin
        nxt       = state;
        cmd_ready = 1'b0;
        ar_valid  = 1'b0;
        wr_en     = 1'b0;
        wr_nan    = 1'b0;
        wr_class  = TAG_VALID;
        pop_en    = 1'b0;
        wr_idx    = (q_to_top || q_use_mem) ? '0 : q_idx;
        unique case (state)
            S_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) nxt = S_EVAL;           // accept
            end
            S_EVAL: begin
                if (fault) begin
                    if (q_mask) begin
                        wr_en    = 1'b1;
                        wr_nan   = 1'b1;
                        wr_class = TAG_SPECIAL;
                    end
                    nxt = S_IDLE;                      // fault
                end else begin
                    nxt = S_ISSUE;                     // go
                end
            end
            S_ISSUE: begin
                ar_valid = 1'b1;
                if (ar_ready) nxt = S_WAIT;            // taken
            end
            S_WAIT: begin
                if (rs_valid) begin
                    wr_en    = !is_cmp;
                    wr_class = rs_class;
                    pop_en   = do_pop;
                    nxt      = S_IDLE;                 // retire
                end
            end
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/fpd_dispatch.sv
module fpd_dispatch
    import fpd_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    output logic         cmd_ready,
    input  logic [2:0]   cmd_op,
    input  logic         cmd_use_mem,
    input  logic [W-1:0] cmd_mem_val,
    input  logic [2:0]   cmd_idx,
    input  logic         cmd_to_top,
    input  logic         cmd_pop,
    input  logic         cmd_mask,
    input  logic         push_valid,
    input  logic [W-1:0] push_val,
    input  logic [1:0]   push_tag,
    input  logic [2:0]   rd_idx,
    output logic [W-1:0] rd_val,
    output logic [1:0]   rd_tag,
    output logic         ar_valid,
    input  logic         ar_ready,
    output logic [2:0]   ar_op,
    output logic [W-1:0] ar_a,
    output logic [W-1:0] ar_b,
    input  logic         rs_valid,
    input  logic [W-1:0] rs_value,
    input  logic [1:0]   rs_class,
    input  logic [3:0]   rs_flags,
    output logic [3:0]   cc_flags,
    output logic [2:0]   top_ptr,
    output logic         inv_sticky,
    output logic         exc_pending
);
    localparam logic [W-1:0] INDEF_NAN =
        {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

    logic [2:0]   q_op;
    logic         q_use_mem;
    logic [W-1:0] q_mem_val;
    logic [2:0]   q_idx;
    logic [W-1:0] st0_val, sti_val;
    logic [1:0]   st0_tag, sti_tag;
    logic         wr_en, wr_nan, pop_en;
    logic [2:0]   wr_idx;
    logic [1:0]   wr_class;
    logic [W-1:0] wr_val;

    assign wr_val = wr_nan ? INDEF_NAN : rs_value;

    fpd_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_use_mem(cmd_use_mem),
        .cmd_mem_val(cmd_mem_val), .cmd_idx(cmd_idx), .cmd_to_top(cmd_to_top),
        .cmd_pop(cmd_pop), .cmd_mask(cmd_mask),
        .tag0(st0_tag), .tagi(sti_tag),
        .ar_ready(ar_ready), .rs_valid(rs_valid), .rs_class(rs_class),
        .rs_flags(rs_flags),
        .cmd_ready(cmd_ready), .ar_valid(ar_valid),
        .q_op(q_op), .q_use_mem(q_use_mem), .q_mem_val(q_mem_val), .q_idx(q_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_nan(wr_nan), .wr_class(wr_class),
        .pop_en(pop_en), .cc_flags(cc_flags), .inv_sticky(inv_sticky),
        .exc_pending(exc_pending)
    );

    fpd_stack #(.W(W)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_valid && cmd_ready), .push_val(push_val), .push_tag(push_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_class),
        .pop_en(pop_en),
        .ra_idx(3'd0), .ra_val(st0_val), .ra_tag(st0_tag),
        .rb_idx(q_idx), .rb_val(sti_val), .rb_tag(sti_tag),
        .rc_idx(rd_idx), .rc_val(rd_val), .rc_tag(rd_tag),
        .top_o(top_ptr)
    );

    fpd_route #(.W(W)) u_route (
        .op(q_op), .use_mem(q_use_mem), .mem_val(q_mem_val),
        .st0_val(st0_val), .sti_val(sti_val),
        .a(ar_a), .b(ar_b), .port_op(ar_op)
    );
endmodule

// File: rtl/fpd_dispatch_chk.sv
module fpd_dispatch_chk #(
    parameter int W = 80
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_ready,
    input logic         ar_valid,
    input logic         ar_ready,
    input logic [2:0]   ar_op,
    input logic [W-1:0] ar_a,
    input logic [W-1:0] ar_b,
    input logic [2:0]   top_ptr,
    input logic         inv_sticky,
    input logic         exc_pending,
    input logic [1:0]   st0_tag
);
    // R10
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_a) && $stable(ar_b) && $stable(ar_op));

    // R10
    busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !cmd_ready);

    // R7
    empty_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> st0_tag != 2'd3);

    // R6
    top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(top_ptr) |-> (top_ptr == 3'($past(top_ptr) + 3'd1)) ||
                              (top_ptr == 3'($past(top_ptr) - 3'd1)));

    // R9
    exc_implies_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pending |-> inv_sticky);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_sticky) |-> inv_sticky);
endmodule

bind fpd_dispatch fpd_dispatch_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .ar_op(ar_op), .ar_a(ar_a), .ar_b(ar_b),
    .top_ptr(top_ptr), .inv_sticky(inv_sticky), .exc_pending(exc_pending),
    .st0_tag(st0_tag)
);

// File: tb/sim_fpd_dispatch.sv
module sim_fpd_dispatch;
    localparam int EXP_W = 5;
    localparam int MAN_W = 10;
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] NAN = 16'hFF00;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cmd_valid, cmd_ready, cmd_use_mem, cmd_to_top, cmd_pop, cmd_mask;
    logic [2:0] cmd_op, cmd_idx, rd_idx, ar_op, top_ptr;
    logic [W-1:0] cmd_mem_val, push_val, rd_val, ar_a, ar_b, rs_value;
    logic push_valid, ar_valid, ar_ready, rs_valid, inv_sticky, exc_pending;
    logic [1:0] push_tag, rd_tag, rs_class;
    logic [3:0] rs_flags, cc_flags;

    fpd_dispatch #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_use_mem(cmd_use_mem), .cmd_mem_val(cmd_mem_val),
        .cmd_idx(cmd_idx), .cmd_to_top(cmd_to_top), .cmd_pop(cmd_pop),
        .cmd_mask(cmd_mask), .push_valid(push_valid), .push_val(push_val),
        .push_tag(push_tag), .rd_idx(rd_idx), .rd_val(rd_val), .rd_tag(rd_tag),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_op(ar_op), .ar_a(ar_a),
        .ar_b(ar_b), .rs_valid(rs_valid), .rs_value(rs_value), .rs_class(rs_class),
        .rs_flags(rs_flags), .cc_flags(cc_flags), .top_ptr(top_ptr),
        .inv_sticky(inv_sticky), .exc_pending(exc_pending)
    );

    int checks = 0;
    int fails = 0;

    logic [W-1:0] m_reg [8];
    logic [1:0]   m_tag [8];
    int           m_top;
    logic         m_inv, m_exc;
    logic [3:0]   m_cc;
    bit           m_sync = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model while the block is idle
    always @(posedge clk) begin
        #5;
        if (m_sync) begin
            chk("R10", "cmd_ready idle", 32'(cmd_ready), 32'd1);
            chk("R6", "top_ptr", 32'(top_ptr), 32'(m_top));
            chk("R7", "inv_sticky", 32'(inv_sticky), 32'(m_inv));
            chk("R9", "exc_pending", 32'(exc_pending), 32'(m_exc));
            chk("R5", "cc_flags", 32'(cc_flags), 32'(m_cc));
        end
    end

    task automatic verify_stack(string req);
        for (int i = 0; i < 8; i++) begin
            int p;
            p = (m_top + i) % 8;
            rd_idx = 3'(i);
            #1;
            chk(req, $sformatf("tag ST%0d", i), 32'(rd_tag), 32'(m_tag[p]));
            if (m_tag[p] != 2'd3)
                chk(req, $sformatf("value ST%0d", i), 32'(rd_val), 32'(m_reg[p]));
        end
    endtask

    task automatic push(logic [W-1:0] v, logic [1:0] t);
        @(negedge clk);
        m_sync = 0;
        push_valid = 1'b1; push_val = v; push_tag = t;
        @(negedge clk);
        push_valid = 1'b0;
        m_top = (m_top + 7) % 8;
        m_reg[m_top] = v;
        m_tag[m_top] = t;
        m_sync = 1;
        verify_stack("R2");
    endtask

    task automatic run(string req, logic [2:0] op, logic mem, logic [W-1:0] mv,
                       logic [2:0] idx, logic to_top, logic pop, logic mask,
                       logic [W-1:0] rv, logic [1:0] rc, logic [3:0] rf, int stall);
        int p0, pi, pd;
        logic inv, rev, saw;
        logic [W-1:0] other, ea, eb;
        logic [2:0] eop;
        p0 = m_top;
        pi = (m_top + idx) % 8;
        inv = (m_tag[p0] == 2'd3) || (!mem && m_tag[pi] == 2'd3);
        other = mem ? mv : m_reg[pi];
        rev = (op == 3'd5) || (op == 3'd7);
        ea = rev ? other : m_reg[p0];
        eb = rev ? m_reg[p0] : other;
        eop = (op == 3'd5) ? 3'd4 : (op == 3'd7) ? 3'd6 : (op == 3'd3) ? 3'd2 : op;
        pd = (to_top || mem) ? p0 : pi;
        saw = 1'b0;

        @(negedge clk);
        m_sync = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_use_mem = mem; cmd_mem_val = mv;
        cmd_idx = idx; cmd_to_top = to_top; cmd_pop = pop; cmd_mask = mask;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int n = 0; n < 60; n++) begin
            if (cmd_ready) break;
            if (ar_valid && !saw) begin
                saw = 1'b1;
                chk("R3", "ar_a", 32'(ar_a), 32'(ea));
                chk("R3", "ar_b", 32'(ar_b), 32'(eb));
                chk("R3", "ar_op", 32'(ar_op), 32'(eop));
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    chk("R10", "ar_valid held", 32'(ar_valid), 32'd1);
                    chk("R10", "ar_a held", 32'(ar_a), 32'(ea));
                end
                ar_ready = 1'b1;
                @(negedge clk);
                ar_ready = 1'b0;
                rs_valid = 1'b1; rs_value = rv; rs_class = rc; rs_flags = rf;
                @(negedge clk);
                rs_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R7", {req, " request issued"}, 32'(saw), 32'(!inv));

        if (inv) begin
            m_inv = 1'b1;
            if (mask) begin
                m_reg[pd] = NAN;
                m_tag[pd] = 2'd2;
                m_exc = 1'b0;
            end else begin
                m_exc = 1'b1;
            end
        end else begin
            m_exc = 1'b0;
            if (op == 3'd2 || op == 3'd3) begin
                m_cc = rf;
            end else begin
                m_reg[pd] = rv;
                m_tag[pd] = rc;
            end
            if (op == 3'd3 || (pop && !mem)) begin
                m_tag[m_top] = 2'd3;
                m_top = (m_top + 1) % 8;
            end
        end
        m_sync = 1;
        verify_stack(req);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_use_mem = 0; cmd_mem_val = 0;
        cmd_idx = 0; cmd_to_top = 0; cmd_pop = 0; cmd_mask = 0;
        push_valid = 0; push_val = 0; push_tag = 0; rd_idx = 0;
        ar_ready = 0; rs_valid = 0; rs_value = 0; rs_class = 0; rs_flags = 0;
        for (int k = 0; k < 8; k++) begin m_reg[k] = '0; m_tag[k] = 2'd3; end
        m_top = 0; m_inv = 0; m_exc = 0; m_cc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R1", "top_ptr", 32'(top_ptr), 32'd0);
        chk("R1", "cc_flags", 32'(cc_flags), 32'd0);
        chk("R1", "inv_sticky", 32'(inv_sticky), 32'd0);
        chk("R1", "exc_pending", 32'(exc_pending), 32'd0);
        verify_stack("R1");
        m_sync = 1;

        // R2 loads
        push(16'h3C00, 2'd0);
        push(16'h4000, 2'd0);
        push(16'h4200, 2'd0);
        push(16'h4400, 2'd0);

        // R3/R4 add with memory operand, result to ST0
        run("R4", 3'd0, 1, 16'h3800, 3'd0, 1, 0, 1, 16'h5555, 2'd0, 4'h0, 0);
        // R3 reverse subtract, register operand ST2, result to ST0 tagged zero
        run("R3", 3'd5, 0, 16'h0, 3'd2, 1, 0, 1, 16'h0000, 2'd1, 4'h0, 1);
        // R4 divide, result to ST1 tagged special
        run("R4", 3'd6, 0, 16'h0, 3'd1, 0, 0, 1, 16'h2222, 2'd2, 4'h0, 0);
        // R4 reverse divide from memory ignores STi destination; R10 stall
        run("R4", 3'd7, 1, 16'h3A00, 3'd3, 0, 0, 1, 16'h3333, 2'd0, 4'h0, 3);
        // R5 compare with ST3: flags only
        run("R5", 3'd2, 0, 16'h0, 3'd3, 1, 0, 1, 16'h7777, 2'd0, 4'hA, 0);
        // R5 compare-and-pop with memory
        run("R5", 3'd3, 1, 16'h3C00, 3'd0, 1, 0, 1, 16'h7777, 2'd0, 4'h5, 0);
        // R6 subtract into ST1 then pop
        run("R6", 3'd4, 0, 16'h0, 3'd1, 0, 1, 1, 16'h4444, 2'd0, 4'h0, 2);
        // R6 pop request with memory operand has no effect
        run("R6", 3'd1, 1, 16'h4000, 3'd0, 1, 1, 1, 16'h4666, 2'd0, 4'h0, 0);
        // R7/R8 masked fault on empty ST2, destination ST0
        run("R8", 3'd0, 0, 16'h0, 3'd2, 1, 0, 1, 16'h1234, 2'd0, 4'h0, 0);
        // R8 masked fault, destination the empty ST2 itself
        run("R8", 3'd0, 0, 16'h0, 3'd2, 0, 1, 1, 16'h1234, 2'd0, 4'h0, 0);
        // R9 unmasked fault: nothing changes, exception pending
        run("R9", 3'd4, 0, 16'h0, 3'd3, 0, 1, 0, 16'h1234, 2'd0, 4'h0, 0);
        // R9 next command clears pending; R6 pops wrap the pointer
        run("R6", 3'd3, 1, 16'h3C00, 3'd0, 1, 0, 1, 16'h0, 2'd0, 4'h3, 0);
        run("R6", 3'd3, 1, 16'h3C00, 3'd0, 1, 0, 1, 16'h0, 2'd0, 4'h6, 0);
        run("R6", 3'd3, 1, 16'h3C00, 3'd0, 1, 0, 1, 16'h0, 2'd0, 4'h9, 0);
        // R7 empty ST0 with memory operand, unmasked then masked
        run("R7", 3'd0, 1, 16'h3C00, 3'd0, 1, 0, 0, 16'h0, 2'd0, 4'h0, 0);
        run("R8", 3'd1, 1, 16'h3C00, 3'd0, 1, 0, 1, 16'h0, 2'd0, 4'h0, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule